// File: doc/BRIEF.md
# Real-Time Clock Alarm, Watchdog and Interrupt Controller

This block produces the interrupt output of a real-time clock. It has three event sources. The first is an alarm comparator that matches programmed BCD date, hour, minute and second values against the running time. Each alarm field can be left out of the comparison on its own. The second is a watchdog that counts 32 Hz ticks down from a programmed timeout and must be re-armed by software before it expires. The third is a power-fail input. Each source sets a sticky flag, and the flags are cleared by reading the flag register. An event whose source is enabled drives the interrupt pin.

The pin is modelled as a data level plus an output enable, so that open-drain and push-pull drive can both be shown. Software chooses the drive type and the assertion mode. In level mode the pin stays asserted until the flags are read. In pulse mode the pin is asserted for a fixed number of ticks after each event. The calendar counter and the bus decoder sit outside this block. The block sees a simple single-cycle register strobe interface, and the current time arrives as four plain BCD bytes. The interface has no back-pressure: a write takes effect at the clock edge where it is strobed, and read data is valid in the cycle of the read strobe.

Register map (3-bit address): 0 alarm seconds, 1 alarm minutes, 2 alarm hours, 3 alarm date, 4 watchdog control, 5 interrupt control, 6 flags.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: Each alarm register holds a 7-bit BCD value in bits 6:0 and an ignore bit in bit 7. A field with its ignore bit at 1 always counts as matching. A field with its ignore bit at 0 matches only when its bits 6:0 equal bits 6:0 of the corresponding current-time input. The alarm flag (flag bit 1) is set only when all four fields match.
- R2: An alarm event happens only in a cycle where cur_sec differs from its value in the previous cycle. Holding a matching time steady after the flag has been read-cleared does not set the flag again.
- R3: Watchdog register bits 5:0 hold the timeout T. Writing with bit 7 at 1 loads the counter with T. After exactly T tick_32hz pulses, the watchdog flag (flag bit 2) is set, and the counter reloads T and keeps running. When T is 0, the watchdog never sets its flag.
- R4: Watchdog bit 6 is a protect bit. A write changes the timeout field only if the stored protect bit was 0 before that write. Every write stores bit 6. The register reads back as {0, protect, timeout}, so the strobe bit always reads as 0.
- R5: A rising edge on pwr_fail sets the power-fail flag (flag bit 0).
- R6: The flag register (address 6) reads back {5'b0, watchdog, alarm, power-fail}. A read clears all three flags. An event in the same cycle as the read still leaves its flag set.
- R7: Interrupt control (address 5) bit 2 enables the watchdog source, bit 1 the alarm source and bit 0 the power-fail source. In level mode the interrupt is active while any flag is set together with its enable bit. A flag whose enable is 0 does not activate the pin.
- R8: Interrupt control bit 3 selects the drive. At 1 the pin is push-pull active high: irq_oe=1 and irq_o equals the active state. At 0 the pin is open-drain active low: irq_o=0 and irq_oe equals the active state.
- R9: Interrupt control bit 4 selects pulse mode. In pulse mode an enabled event makes the pin active for PULSE_TICKS ticks, whether or not its flag is still set. A read of the flag register ends the pulse early.
- R10: After reset, every register reads 0 and the pin is released (irq_oe=0, irq_o=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the flag register clears the flags) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, valid in the same cycle |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| tick_32hz | input | 1 | One-cycle pulse at each 32 Hz tick |
| pwr_fail | input | 1 | Power-fail level from the supply monitor |
| irq_o | output | 1 | Interrupt pin data level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with PULSE_TICKS=3. This keeps the pulse-mode window short enough to walk tick by tick, and it still checks both the natural end of the pulse and the early end caused by a flag read. The 6-bit timeout keeps its full width, so the bench sweeps all 63 nonzero timeouts and checks that the expiry lands on exactly the T-th tick. With only four alarm fields, the bench can apply all 16 ignore masks against all 16 match/mismatch patterns of the current time.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int NFIELD   = 4;
  localparam int TMO_W    = 6;
  localparam int NSRC     = 3;

  localparam logic [ADDR_W-1:0] A_WDOG  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ICTL  = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd6;

  // source index; shared by flags and enables
  localparam int SRC_PF = 0;
  localparam int SRC_AL = 1;
  localparam int SRC_WD = 2;

  // interrupt control bit positions
  localparam int ICTL_POL   = 3;
  localparam int ICTL_PULSE = 4;
  localparam int ICTL_W     = 5;

  // watchdog control bit positions
  localparam int WD_STROBE  = 7;
  localparam int WD_PROTECT = 6;

  typedef logic [DATA_W-1:0] rbyte_t;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_irq_pkg::*;
#(
  parameter int N = NFIELD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rbyte_t [N-1:0]   alarm,
  input  rbyte_t [N-1:0]   now,
  output logic             hit
);
  logic [N-1:0] fld_ok;
  rbyte_t       sec_q;

  for (genvar i = 0; i < N; i++) begin : g_fld
    assign fld_ok[i] = alarm[i][DATA_W-1] |
                       (alarm[i][DATA_W-2:0] == now[i][DATA_W-2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_q <= '0;
    else        sec_q <= now[0];
  end

  assign hit = (&fld_ok) && (now[0] != sec_q);
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog
  import rtc_irq_pkg::*;
#(
  parameter int W = TMO_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] timeout,
  output logic         expire
);
  logic [W-1:0] cnt_q;
  logic         armed;

  assign armed  = (timeout != '0) && (cnt_q != '0);
  assign expire = !load && tick && armed && (cnt_q == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (timeout == '0)    cnt_q <= '0;
    else if (tick && armed) begin
      if (cnt_q == W'(1))      cnt_q <= timeout;
      else                     cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/rtc_irq_out.sv
module rtc_irq_out
  import rtc_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 6,
  localparam int PW = $clog2(PULSE_TICKS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] en,
  input  logic            flag_clr,
  input  logic            pol_hi,
  input  logic            pulse_mode,
  output logic [NSRC-1:0] flags,
  output logic            fire,
  output logic [PW-1:0]   pulse_cnt,
  output logic            irq_o,
  output logic            irq_oe
);
  logic active;

  assign fire = |(evt & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~{NSRC{flag_clr}}) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pulse_cnt <= '0;
    else if (fire)                       pulse_cnt <= PW'(PULSE_TICKS);
    else if (flag_clr)                   pulse_cnt <= '0;
    else if (tick && pulse_cnt != '0)    pulse_cnt <= pulse_cnt - PW'(1);
  end

  assign active = pulse_mode ? (pulse_cnt != '0) : |(flags & en);
  assign irq_oe = pol_hi ? 1'b1 : active;
  assign irq_o  = pol_hi ? active : 1'b0;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 6,
  localparam int PW = $clog2(PULSE_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] cur_sec,
  input  logic [DATA_W-1:0] cur_min,
  input  logic [DATA_W-1:0] cur_hour,
  input  logic [DATA_W-1:0] cur_date,
  input  logic              tick_32hz,
  input  logic              pwr_fail,
  output logic              irq_o,
  output logic              irq_oe
);
  rbyte_t [NFIELD-1:0] alarm_q;
  rbyte_t [NFIELD-1:0] now;
  logic [TMO_W-1:0]    wd_tmo_q, wd_tmo_d;
  logic                wd_lock_q;
  logic [ICTL_W-1:0]   ictl_q;
  logic                wd_wr, wd_load;
  logic                al_hit, wd_exp, pf_q, pf_rise;
  logic [NSRC-1:0]     evt, flags;
  logic                flag_rd, fire;
  logic [PW-1:0]       pulse_cnt;

  assign now     = {cur_date, cur_hour, cur_min, cur_sec};
  assign wd_wr   = reg_wr && (reg_addr == A_WDOG);
  assign wd_load = wd_wr && reg_wdata[WD_STROBE];
  assign flag_rd = reg_rd && (reg_addr == A_FLAGS);

  // timeout field takes a write only when the protect bit was clear before
  assign wd_tmo_d = (wd_wr && !wd_lock_q) ? reg_wdata[TMO_W-1:0] : wd_tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q   <= '0;
      wd_tmo_q  <= '0;
      wd_lock_q <= 1'b0;
      ictl_q    <= '0;
    end else begin
      wd_tmo_q <= wd_tmo_d;
      if (wd_wr) wd_lock_q <= reg_wdata[WD_PROTECT];
      if (reg_wr && reg_addr == A_ICTL) ictl_q <= reg_wdata[ICTL_W-1:0];
      if (reg_wr && reg_addr < ADDR_W'(NFIELD))
        alarm_q[reg_addr[1:0]] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pf_q <= 1'b0;
    else        pf_q <= pwr_fail;
  end
  assign pf_rise = pwr_fail && !pf_q;

  rtc_alarm_match #(.N(NFIELD)) u_alarm (
    .clk   (clk),
    .rst_n (rst_n),
    .alarm (alarm_q),
    .now   (now),
    .hit   (al_hit)
  );

  rtc_wdog #(.W(TMO_W)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_32hz),
    .load     (wd_load),
    .load_val (wd_tmo_d),
    .timeout  (wd_tmo_q),
    .expire   (wd_exp)
  );

  always_comb begin
    evt         = '0;
    evt[SRC_PF] = pf_rise;
    evt[SRC_AL] = al_hit;
    evt[SRC_WD] = wd_exp;
  end

  rtc_irq_out #(.PULSE_TICKS(PULSE_TICKS)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_32hz),
    .evt        (evt),
    .en         (ictl_q[NSRC-1:0]),
    .flag_clr   (flag_rd),
    .pol_hi     (ictl_q[ICTL_POL]),
    .pulse_mode (ictl_q[ICTL_PULSE]),
    .flags      (flags),
    .fire       (fire),
    .pulse_cnt  (pulse_cnt),
    .irq_o      (irq_o),
    .irq_oe     (irq_oe)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < ADDR_W'(NFIELD)) reg_rdata = alarm_q[reg_addr[1:0]];
    else if (reg_addr == A_WDOG)    reg_rdata = {1'b0, wd_lock_q, wd_tmo_q};
    else if (reg_addr == A_ICTL)    reg_rdata = DATA_W'(ictl_q);
    else if (reg_addr == A_FLAGS)   reg_rdata = DATA_W'(flags);
  end
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk
  import rtc_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 6,
  localparam int PW = $clog2(PULSE_TICKS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cur_sec,
  input logic              pwr_fail,
  input logic              irq_o,
  input logic              irq_oe,
  input logic              pol,
  input logic              flag_rd,
  input logic [NSRC-1:0]   evt,
  input logic [NSRC-1:0]   flags,
  input logic              wd_wr,
  input logic              wd_lock,
  input logic [TMO_W-1:0]  wd_tmo,
  input logic              fire,
  input logic [PW-1:0]     pulse_cnt
);
  a_r8_pushpull_drives: assert property (@(posedge clk) disable iff (!rst_n)
    pol |-> irq_oe);

  a_r8_opendrain_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pol |-> !irq_o);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && evt == '0) |=> (flags == '0));

  a_r4_locked_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_wr && wd_lock) |=> $stable(wd_tmo));

  a_r3_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_tmo == '0) |-> !evt[SRC_WD]);

  a_r2_needs_sec_change: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(cur_sec)) |-> !evt[SRC_AL]);

  a_r5_pf_edge_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(pwr_fail)) |=> flags[SRC_PF]);

  a_r9_pulse_only_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (pulse_cnt <= $past(pulse_cnt)));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cur_sec   (cur_sec),
  .pwr_fail  (pwr_fail),
  .irq_o     (irq_o),
  .irq_oe    (irq_oe),
  .pol       (ictl_q[3]),
  .flag_rd   (flag_rd),
  .evt       (evt),
  .flags     (flags),
  .wd_wr     (wd_wr),
  .wd_lock   (wd_lock_q),
  .wd_tmo    (wd_tmo_q),
  .fire      (fire),
  .pulse_cnt (pulse_cnt)
);

// File: tb/sim_rtc_irq_ctrl.sv
module sim_rtc_irq_ctrl;
  localparam int P = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
  logic       tick_32hz = 1'b0, pwr_fail = 1'b0;
  logic       irq_o, irq_oe;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rtc_irq_ctrl #(.PULSE_TICKS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .tick_32hz(tick_32hz), .pwr_fail(pwr_fail),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_32hz = 1'b1;
      @(negedge clk); tick_32hz = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] al [4];
    logic [7:0] miss [4];
    logic [7:0] setup [4];
    al    = '{8'h30, 8'h15, 8'h08, 8'h12};
    miss  = '{8'h31, 8'h16, 8'h09, 8'h13};
    setup = '{8'h45, 8'h44, 8'h23, 8'h28};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d); chk("R10 reg reset", d, 8'h00);
    end
    chk("R10 irq_oe reset", {7'b0, irq_oe}, 8'h00);
    chk("R10 irq_o reset", {7'b0, irq_o}, 8'h00);

    // R4 protect handshake
    wr(3'd4, 8'h45); rd(3'd4, d); chk("R4 set protect", d, 8'h45);
    wr(3'd4, 8'h09); rd(3'd4, d); chk("R4 locked write ignored", d, 8'h05);
    wr(3'd4, 8'h09); rd(3'd4, d); chk("R4 unlocked write", d, 8'h09);
    wr(3'd4, 8'h8A); rd(3'd4, d); chk("R4 strobe reads 0", d, 8'h0A);
    wr(3'd4, 8'h00);

    // R3 full timeout sweep, push-pull, watchdog enabled (R7 R8)
    wr(3'd5, 8'h0C);
    for (int t = 1; t < 64; t++) begin
      wr(3'd4, {2'b10, 6'(t)});
      ticks(t - 1);
      chk("R3 before expiry", {7'b0, irq_o}, 8'h00);
      ticks(1);
      chk("R3 at expiry irq", {7'b0, irq_o}, 8'h01);
      chk("R8 push-pull oe", {7'b0, irq_oe}, 8'h01);
      rd(3'd6, d); chk("R3 R6 wd flag", d, 8'h04);
      chk("R7 level cleared by read", {7'b0, irq_o}, 8'h00);
    end
    // R3 keeps running after expiry
    wr(3'd4, 8'h82);
    ticks(2); rd(3'd6, d); chk("R3 first period", d, 8'h04);
    ticks(1); rd(3'd6, d); chk("R3 mid second period", d, 8'h00);
    ticks(1); rd(3'd6, d); chk("R3 second period", d, 8'h04);
    // R3 timeout 0 disables
    wr(3'd4, 8'h80);
    ticks(70); rd(3'd6, d); chk("R3 zero timeout quiet", d, 8'h00);

    // R1 R2 alarm mask x pattern sweep
    wr(3'd5, 8'h0A);
    for (int m = 0; m < 16; m++) begin
      for (int f = 0; f < 4; f++) wr(3'(f), {m[f], al[f][6:0]});
      for (int p = 0; p < 16; p++) begin
        logic e;
        @(negedge clk);
        cur_sec = setup[0]; cur_min = setup[1]; cur_hour = setup[2]; cur_date = setup[3];
        rd(3'd6, d);
        @(negedge clk);
        cur_sec  = p[0] ? al[0] : miss[0];
        cur_min  = p[1] ? al[1] : miss[1];
        cur_hour = p[2] ? al[2] : miss[2];
        cur_date = p[3] ? al[3] : miss[3];
        e = &(4'(m) | 4'(p));
        rd(3'd6, d); chk("R1 alarm flag", d, {6'b0, e, 1'b0});
        if (e) begin
          repeat (3) @(negedge clk);
          rd(3'd6, d); chk("R2 no refire while held", d, 8'h00);
        end
      end
    end

    // R5 R8 power fail, open drain
    wr(3'd5, 8'h01);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    chk("R8 open-drain oe", {7'b0, irq_oe}, 8'h01);
    chk("R8 open-drain low", {7'b0, irq_o}, 8'h00);
    rd(3'd6, d); chk("R5 pf flag", d, 8'h01);
    chk("R8 released after read", {7'b0, irq_oe}, 8'h00);
    @(negedge clk); pwr_fail = 1'b0;
    // R7 disabled source
    wr(3'd5, 8'h00);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    chk("R7 disabled no drive", {7'b0, irq_oe}, 8'h00);
    rd(3'd6, d); chk("R7 flag still set", d, 8'h01);
    @(negedge clk); pwr_fail = 1'b0;
    // R6 set in same cycle as read wins
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd6; pwr_fail = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
    chk("R6 read before set", d, 8'h00);
    rd(3'd6, d); chk("R6 set beats clear", d, 8'h01);
    @(negedge clk); pwr_fail = 1'b0;

    // R9 pulse mode, push-pull
    wr(3'd5, 8'h19);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    chk("R9 pulse start", {7'b0, irq_o}, 8'h01);
    ticks(P - 1);
    chk("R9 pulse held", {7'b0, irq_o}, 8'h01);
    ticks(1);
    chk("R9 pulse ended", {7'b0, irq_o}, 8'h00);
    rd(3'd6, d); chk("R9 flag outlives pulse", d, 8'h01);
    @(negedge clk); pwr_fail = 1'b0;
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    chk("R9 second pulse", {7'b0, irq_o}, 8'h01);
    rd(3'd6, d);
    chk("R9 read ends pulse", {7'b0, irq_o}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule